// File: doc/BRIEF.md
# Test access port with combined internal-and-boundary scan path

This block is a five-pin serial test access port in the IEEE 1149.1 style. A 16-state controller is stepped by TMS on each rising TCK edge. A 3-bit instruction register selects which data register sits between TDI and TDO. The data register is either a one-bit bypass stage or a boundary register with a shift stage and an update latch. The boundary register has one cell per pad, and its length is a parameter (default 151). In the sample, preload and external-test instructions, the boundary cells capture the pad inputs, and shifted data reaches the update latches in Update-DR. Only the external-test instruction lets those latches drive the pads. In every other instruction the pads carry the core's functional outputs.

A user instruction, called scan-through here, puts the core's single internal scan chain in series with the boundary register. TDI feeds the internal chain, the chain's last bit feeds the top boundary cell, and boundary cell 0 drives TDO. The whole chip is then one TAP-controlled shift path, so burn-in and diagnostics need no dedicated scan pins. While scan-through is active, the core's scan enable is raised only in Shift-DR. The core's capture enable is raised for exactly the one Capture-DR cycle, which gives the core one functional capture clock.

TDO is updated on falling TCK. A separate enable flag is high only in the shift states, and a pad buffer outside the block uses that flag.

Top module: `jtag_scan_tap`

## Requirements
- R1: While trst_n is low, the controller is held in Test-Logic-Reset. The instruction becomes BYPASS (code 3'b111), tdo_en and core_scan_en go low, and pad_out follows core_out. The outputs that are reset asynchronously (tdo_en and pad_out) react without waiting for a clock.
- R2: From any state, five consecutive rising TCK edges with TMS high reach Test-Logic-Reset. As a result any loaded instruction is replaced by BYPASS.
- R3: In Capture-IR the instruction shift stage loads 3'b001. In Shift-IR it shifts LSB first toward TDO, and the new instruction takes effect when the controller leaves Update-IR.
- R4: Code 3'b111 and the unassigned codes (3'b001, 3'b101, 3'b110) select a one-bit bypass stage. It captures 0, so TDO repeats TDI one shift later, with a leading 0.
- R5: SAMPLE (3'b010) and PRELOAD (3'b011) capture pad_in into the boundary cells. Cell 0 reaches TDO first, and the shifted data is loaded into the update latches. pad_out stays equal to core_out in both instructions.
- R6: EXTEST (3'b000) drives pad_out from the boundary update latches.
- R7: Scan-through (3'b100) forms one path of CORE_LEN+BSR_LEN bits, in the order TDI, internal chain, boundary cells BSR_LEN-1 down to 0, TDO. The captured boundary bits leave TDO before the captured core bits.
- R8: core_scan_en is high only in Shift-DR under scan-through. core_capture_en is high for exactly one TCK cycle in each scan-through Capture-DR, and both stay low under every other instruction.
- R9: TDO changes only on falling TCK. tdo_en is high exactly while the controller is in Shift-IR or Shift-DR.
- R10: The boundary update latches change only in Update-DR, so pad_out under EXTEST holds steady throughout a shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, updated on falling tck |
| tdo_en | output | 1 | High while tdo must be driven |
| core_scan_in | output | 1 | Serial input to the core's internal scan chain |
| core_scan_out | input | 1 | Serial output of the core's internal scan chain |
| core_scan_en | output | 1 | Core scan shift enable |
| core_capture_en | output | 1 | One-cycle functional capture enable for the core |
| pad_in | input | BSR_LEN | Values present at the pads |
| core_out | input | BSR_LEN | Functional values the core wants on the pads |
| pad_out | output | BSR_LEN | Values delivered to the pad drivers |

## Verification
The controller state cannot be seen directly, but a wrong state shows up at the ports within one TCK cycle. The tdo_en flag rises or falls at the wrong falling edge. core_scan_en or core_capture_en pulse in the wrong cycle, and the shifted-out word is offset by one or more bit positions. A corrupted instruction or a misrouted chain shows up at the end of one shift. The path length or order is then wrong, pad_out follows the wrong source, or the core chain model holds the wrong bits. A latch that moves outside Update-DR is visible on pad_out during the shift itself.

// File: rtl/jtag_scan_tap_pkg.sv
package jtag_scan_tap_pkg;

   localparam int IR_W = 3;

   typedef enum logic [3:0] {
      S_RESET, S_IDLE,
      S_DR_SEL, S_DR_CAP, S_DR_SHIFT, S_DR_EXIT1, S_DR_PAUSE, S_DR_EXIT2, S_DR_UPD,
      S_IR_SEL, S_IR_CAP, S_IR_SHIFT, S_IR_EXIT1, S_IR_PAUSE, S_IR_EXIT2, S_IR_UPD
   } tap_state_e;

   localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
   localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b010;
   localparam logic [IR_W-1:0] OP_PRELOAD = 3'b011;
   localparam logic [IR_W-1:0] OP_THRU    = 3'b100;
   localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
   localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

   function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
      tap_state_e n;
      case (s)
         S_RESET:    n = m ? S_RESET    : S_IDLE;
         S_IDLE:     n = m ? S_DR_SEL   : S_IDLE;
         S_DR_SEL:   n = m ? S_IR_SEL   : S_DR_CAP;
         S_DR_CAP:   n = m ? S_DR_EXIT1 : S_DR_SHIFT;
         S_DR_SHIFT: n = m ? S_DR_EXIT1 : S_DR_SHIFT;
         S_DR_EXIT1: n = m ? S_DR_UPD   : S_DR_PAUSE;
         S_DR_PAUSE: n = m ? S_DR_EXIT2 : S_DR_PAUSE;
         S_DR_EXIT2: n = m ? S_DR_UPD   : S_DR_SHIFT;
         S_DR_UPD:   n = m ? S_DR_SEL   : S_IDLE;
         S_IR_SEL:   n = m ? S_RESET    : S_IR_CAP;
         S_IR_CAP:   n = m ? S_IR_EXIT1 : S_IR_SHIFT;
         S_IR_SHIFT: n = m ? S_IR_EXIT1 : S_IR_SHIFT;
         S_IR_EXIT1: n = m ? S_IR_UPD   : S_IR_PAUSE;
         S_IR_PAUSE: n = m ? S_IR_EXIT2 : S_IR_PAUSE;
         S_IR_EXIT2: n = m ? S_IR_UPD   : S_IR_SHIFT;
         S_IR_UPD:   n = m ? S_DR_SEL   : S_IDLE;
         default:    n = S_RESET;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/tap_ctrl_fsm.sv
module tap_ctrl_fsm
   import jtag_scan_tap_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   output tap_state_e state
);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) state <= S_RESET;
      else         state <= tap_next(state, tms);
   end

   // Run length of TMS-high edges, kept for the checks below.
   logic [2:0] tms_run;
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)           tms_run <= '0;
      else if (!tms)         tms_run <= '0;
      else if (tms_run != 7) tms_run <= tms_run + 3'd1;
   end

   p_trst_holds_reset_r1: assert property (@(posedge tck) !trst_n |=> state == S_RESET)
      else $error("R1: state not reset under trst_n");

   p_five_ones_reset_r2: assert property (@(posedge tck) disable iff (!trst_n)
      tms_run >= 3'd5 |-> state == S_RESET)
      else $error("R2: five TMS-high edges did not reach reset");

endmodule

// File: rtl/tap_instr_reg.sv
module tap_instr_reg
   import jtag_scan_tap_pkg::*;
(
   input  logic            tck,
   input  logic            trst_n,
   input  tap_state_e      state,
   input  logic            tdi,
   output logic            ir_so,
   output logic [IR_W-1:0] instr
);

   if (IR_W < 2) begin : g_chk_w
      $error("instruction register must hold the 2-bit capture pattern");
   end

   logic [IR_W-1:0] sh;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                 sh <= IR_CAPTURE;
      else if (state == S_IR_CAP)  sh <= IR_CAPTURE;
      else if (state == S_IR_SHIFT) sh <= {tdi, sh[IR_W-1:1]};
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                instr <= OP_BYPASS;
      else if (state == S_RESET)  instr <= OP_BYPASS;
      else if (state == S_IR_UPD) instr <= sh;
   end

   assign ir_so = sh[0];

   p_reset_loads_bypass_r1: assert property (@(posedge tck) disable iff (!trst_n)
      state == S_RESET |=> instr == OP_BYPASS)
      else $error("R1: Test-Logic-Reset did not load BYPASS");

   p_instr_only_on_update_r3: assert property (@(posedge tck) disable iff (!trst_n)
      (state != S_IR_UPD && state != S_RESET) |=> $stable(instr))
      else $error("R3: instruction changed outside Update-IR");

endmodule

// File: rtl/bsr_chain.sv
module bsr_chain #(
   parameter int LEN = 151
) (
   input  logic           tck,
   input  logic           trst_n,
   input  logic           cap_en,
   input  logic           shift_en,
   input  logic           upd_en,
   input  logic           si,
   input  logic [LEN-1:0] pins_in,
   output logic           so,
   output logic [LEN-1:0] upd_q
);

   if (LEN < 1) begin : g_chk_len
      $error("boundary register needs at least one cell");
   end

   logic [LEN-1:0] sh;
   logic [LEN-1:0] sh_next;

   // Each cell takes its neighbour above; the top cell takes the serial input.
   for (genvar i = 0; i < LEN; i++) begin : g_cell
      if (i == LEN - 1) begin : g_top
         assign sh_next[i] = si;
      end else begin : g_mid
         assign sh_next[i] = sh[i+1];
      end
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)       sh <= '0;
      else if (cap_en)   sh <= pins_in;
      else if (shift_en) sh <= sh_next;
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)     upd_q <= '0;
      else if (upd_en) upd_q <= sh;
   end

   assign so = sh[0];

   p_latch_hold_r10: assert property (@(posedge tck) disable iff (!trst_n)
      !upd_en |=> $stable(upd_q))
      else $error("R10: update latch moved outside Update-DR");

endmodule

// File: rtl/jtag_scan_tap.sv
module jtag_scan_tap
   import jtag_scan_tap_pkg::*;
#(
   parameter int BSR_LEN = 151
) (
   input  logic               tck,
   input  logic               trst_n,
   input  logic               tms,
   input  logic               tdi,
   output logic               tdo,
   output logic               tdo_en,
   output logic               core_scan_in,
   input  logic               core_scan_out,
   output logic               core_scan_en,
   output logic               core_capture_en,
   input  logic [BSR_LEN-1:0] pad_in,
   input  logic [BSR_LEN-1:0] core_out,
   output logic [BSR_LEN-1:0] pad_out
);

   tap_state_e      state;
   logic [IR_W-1:0] instr;
   logic            ir_so;
   logic            bsr_so;
   logic [BSR_LEN-1:0] upd_q;
   logic            byp_q;

   tap_ctrl_fsm u_fsm (
      .tck    (tck),
      .trst_n (trst_n),
      .tms    (tms),
      .state  (state)
   );

   tap_instr_reg u_ir (
      .tck    (tck),
      .trst_n (trst_n),
      .state  (state),
      .tdi    (tdi),
      .ir_so  (ir_so),
      .instr  (instr)
   );

   logic sel_thru, sel_extest, sel_bsr;
   assign sel_thru   = (instr == OP_THRU);
   assign sel_extest = (instr == OP_EXTEST);
   assign sel_bsr    = sel_thru || sel_extest ||
                       (instr == OP_SAMPLE) || (instr == OP_PRELOAD);

   logic dr_cap, dr_shift, dr_upd, in_shift;
   assign dr_cap   = (state == S_DR_CAP);
   assign dr_shift = (state == S_DR_SHIFT);
   assign dr_upd   = (state == S_DR_UPD);
   assign in_shift = dr_shift || (state == S_IR_SHIFT);

   bsr_chain #(.LEN(BSR_LEN)) u_bsr (
      .tck      (tck),
      .trst_n   (trst_n),
      .cap_en   (dr_cap && sel_bsr),
      .shift_en (dr_shift && sel_bsr),
      .upd_en   (dr_upd && sel_bsr),
      .si       (sel_thru ? core_scan_out : tdi),
      .pins_in  (pad_in),
      .so       (bsr_so),
      .upd_q    (upd_q)
   );

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                  byp_q <= 1'b0;
      else if (dr_cap && !sel_bsr)  byp_q <= 1'b0;
      else if (dr_shift && !sel_bsr) byp_q <= tdi;
   end

   assign core_scan_in    = tdi;
   assign core_scan_en    = sel_thru && dr_shift;
   assign core_capture_en = sel_thru && dr_cap;
   assign pad_out         = sel_extest ? upd_q : core_out;

   logic ser_out;
   assign ser_out = (state == S_IR_SHIFT) ? ir_so : (sel_bsr ? bsr_so : byp_q);

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo    <= 1'b0;
         tdo_en <= 1'b0;
      end else begin
         tdo_en <= in_shift;
         if (in_shift) tdo <= ser_out;
      end
   end

   p_capture_single_r8: assert property (@(posedge tck) disable iff (!trst_n)
      core_capture_en |=> !core_capture_en)
      else $error("R8: capture enable longer than one cycle");

   p_scan_en_path_r8: assert property (@(posedge tck) disable iff (!trst_n)
      core_scan_en |-> ($past(state) == S_DR_CAP || $past(state) == S_DR_SHIFT ||
                        $past(state) == S_DR_EXIT2))
      else $error("R8: scan enable outside a Shift-DR entry");

   p_tdo_en_shift_r9: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_en |-> (state == S_DR_SHIFT || state == S_IR_SHIFT))
      else $error("R9: tdo_en outside shift states");

endmodule

// File: tb/tb_jtag_scan_tap.sv
module tb_jtag_scan_tap;

   localparam int N  = 8;
   localparam int CL = 6;
   localparam logic [CL-1:0] CAP_PAT  = 6'b100110;
   localparam logic [N-1:0]  CORE_VAL = 8'h6E;

   logic tck = 1'b0;
   logic trst_n, tms, tdi;
   logic tdo, tdo_en, core_scan_in, core_scan_en, core_capture_en;
   logic core_scan_out;
   logic [N-1:0] pad_in, pad_out;

   always #10 tck = ~tck;

   jtag_scan_tap #(.BSR_LEN(N)) dut (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
      .tdo(tdo), .tdo_en(tdo_en),
      .core_scan_in(core_scan_in), .core_scan_out(core_scan_out),
      .core_scan_en(core_scan_en), .core_capture_en(core_capture_en),
      .pad_in(pad_in), .core_out(CORE_VAL), .pad_out(pad_out)
   );

   // Behavioural model of the core's single internal chain.
   logic [CL-1:0] chain;
   always @(posedge tck) begin
      if (core_scan_en)         chain <= {core_scan_in, chain[CL-1:1]};
      else if (core_capture_en) chain <= CAP_PAT;
   end
   assign core_scan_out = chain[0];

   int cap_cnt = 0, sc_cnt = 0;
   always @(posedge tck) begin
      if (core_capture_en) cap_cnt++;
      if (core_scan_en)    sc_cnt++;
   end

   int checks = 0, errors = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge tck);
      @(negedge tck);
      #1;
   endtask

   task automatic step(input logic m);
      tms = m;
      tick();
   endtask

   task automatic load_ir(input logic [2:0] code, output logic [2:0] cap);
      step(1); step(1); step(0); step(0);   // -> Shift-IR
      for (int i = 0; i < 3; i++) begin
         tdi = code[i];
         tms = (i == 2);
         cap[i] = tdo;
         tick();
      end
      step(1); step(0);                     // Update-IR -> Idle
   endtask

   task automatic scan_dr(input int len, input logic [31:0] din,
                          output logic [31:0] dout, output bit en_ok, output bit pad_ok);
      logic [N-1:0] p0;
      dout = '0;
      en_ok = 1'b1;
      step(1); step(0); step(0);            // -> Shift-DR
      p0 = pad_out;
      pad_ok = 1'b1;
      for (int i = 0; i < len; i++) begin
         tdi = din[i];
         tms = (i == len - 1);
         dout[i] = tdo;
         if (!tdo_en) en_ok = 1'b0;
         if (pad_out !== p0) pad_ok = 1'b0;
         tick();
      end
      if (tdo_en) en_ok = 1'b0;             // Exit1-DR: flag must be low
      step(1); step(0);                     // Update-DR -> Idle
   endtask

   // {code[47:45], len[44:40], pads[39:32], din[31:16], exp[15:0]}
   localparam logic [47:0] VEC [5] = '{
      {3'b111, 5'd8,  8'h00, 16'h00B2, 16'h0064},   // R4 bypass
      {3'b101, 5'd8,  8'h00, 16'h000F, 16'h001E},   // R4 unassigned code
      {3'b010, 5'd8,  8'h5A, 16'h0033, 16'h005A},   // R5 sample
      {3'b011, 5'd8,  8'hC3, 16'h0096, 16'h00C3},   // R5 preload
      {3'b100, 5'd14, 8'hA5, 16'h2B4C, 16'h26A5}    // R7 scan-through
   };

   initial begin
      #(20 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [2:0]  irc;
      logic [31:0] dout;
      bit en_ok, pad_ok;
      int c0, s0;
      trst_n = 1'b0; tms = 1'b1; tdi = 1'b0; pad_in = '0;
      repeat (3) tick();
      // R1 reset state
      chk(tdo_en == 1'b0 && core_scan_en == 1'b0 && core_capture_en == 1'b0, "R1 reset outputs",
          {tdo_en, core_scan_en, core_capture_en}, 0);
      chk(pad_out == CORE_VAL, "R1 pads follow core", pad_out, CORE_VAL);
      trst_n = 1'b1;
      step(0);

      foreach (VEC[k]) begin
         logic [2:0]  code;
         int          len;
         logic [31:0] mask;
         code   = VEC[k][47:45];
         len    = int'(VEC[k][44:40]);
         pad_in = VEC[k][39:32];
         mask   = (32'd1 << len) - 1;
         load_ir(code, irc);
         chk(irc == 3'b001, "R3 IR capture pattern", irc, 3'b001);
         c0 = cap_cnt; s0 = sc_cnt;
         scan_dr(len, {16'h0, VEC[k][31:16]}, dout, en_ok, pad_ok);
         chk((dout & mask) == {16'h0, VEC[k][15:0]}, "R4/R5/R7 shifted word", dout & mask, VEC[k][15:0]);
         chk(en_ok, "R9 tdo_en during shift", en_ok, 1);
         chk(cap_cnt - c0 == (code == 3'b100 ? 1 : 0), "R8 capture pulses",
             cap_cnt - c0, (code == 3'b100 ? 1 : 0));
         chk(sc_cnt - s0 == (code == 3'b100 ? len : 0), "R8 scan-enable cycles",
             sc_cnt - s0, (code == 3'b100 ? len : 0));
         if (code != 3'b000)
            chk(pad_out == CORE_VAL, "R5 pads not driven by cells", pad_out, CORE_VAL);
      end

      // R7: core chain and boundary latches after scan-through
      chk(chain == 6'h2B, "R7 core chain contents", chain, 6'h2B);
      load_ir(3'b000, irc);
      chk(pad_out == 8'h4C, "R7 boundary part of path", pad_out, 8'h4C);

      // R5 preload, then R6 extest
      load_ir(3'b011, irc);
      scan_dr(8, 32'h3C, dout, en_ok, pad_ok);
      chk(pad_out == CORE_VAL, "R5 preload keeps core on pads", pad_out, CORE_VAL);
      load_ir(3'b000, irc);
      chk(pad_out == 8'h3C, "R6 extest drives latches", pad_out, 8'h3C);
      scan_dr(8, 32'h81, dout, en_ok, pad_ok);
      chk(pad_ok, "R10 pads stable during shift", pad_ok, 1);
      chk(pad_out == 8'h81, "R6 extest after update", pad_out, 8'h81);

      // R2: five TMS-high edges reset the instruction
      repeat (5) step(1);
      chk(pad_out == CORE_VAL, "R2 TMS reset to bypass", pad_out, CORE_VAL);
      chk(tdo_en == 1'b0, "R2 tdo_en low in reset", tdo_en, 0);
      step(0);

      // R9: tdo moves on falling edge only (bypass, captured 0 then 1)
      load_ir(3'b111, irc);
      step(1); step(0); step(0);
      chk(tdo == 1'b0, "R4 bypass captured zero", tdo, 0);
      tdi = 1'b1; tms = 1'b0;
      @(posedge tck); #1;
      chk(tdo == 1'b0, "R9 tdo held at rising edge", tdo, 0);
      @(negedge tck); #1;
      chk(tdo == 1'b1, "R9 tdo updated at falling edge", tdo, 1);

      // R1: asynchronous reset mid-shift under extest
      step(1); step(1); step(0);            // Exit1 -> Update -> Idle
      load_ir(3'b000, irc);
      step(1); step(0); step(0);
      trst_n = 1'b0;
      #1;
      chk(tdo_en == 1'b0, "R1 async reset clears tdo_en", tdo_en, 0);
      chk(pad_out == CORE_VAL, "R1 async reset returns pads", pad_out, CORE_VAL);
      tick();
      chk(core_scan_en == 1'b0, "R1 scan enable low in reset", core_scan_en, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule